// File: doc/BRIEF.md
# Disk Geometry Bisection Prober

This block works out how many heads, cylinders and sectors a disk has when nothing about it is known in advance. It does this by asking a separate command executor to perform trial seeks to chosen head/cylinder/sector positions. A trial that succeeds shows the position exists. A trial that fails shows it lies beyond the disk's edge. Each dimension is narrowed by halving a bracket `[lo, hi)` until the bracket holds a single value.

The dimensions are resolved one after another, heads first, then cylinders, then sectors. While one dimension is being narrowed, the dimensions already resolved are held at their largest valid index. The dimensions still to come are held at zero, so every trial is a position that is known to be valid in all other dimensions. When all three dimensions have converged, the block reports the three counts with a valid flag. A start pulse throws away any search in progress and begins again. The executor interface is a one-cycle request strobe carrying the trial position, answered later by a done strobe with a pass/fail flag.

Top module: `geo_prober`

## Requirements
- R1: After reset, `geom_valid_o` and `trial_req_o` are 0 and all three count outputs are 0. No trial is issued until `start_i` is pulsed.
- R2: A `start_i` pulse sets every lower bound to 0 and the upper bounds to HEAD_MAX, CYL_MAX and SEC_MAX, and restarts the search. This also applies in the middle of a search with a trial outstanding, whose answer is then never awaited. In the cycle after `start_i`, `geom_valid_o` and `trial_req_o` are 0.
- R3: The dimensions are searched strictly in the order heads, then cylinders, then sectors. With the default power-of-two maxima, exactly 4, 10 and 6 trials are issued in the three phases, 20 in total.
- R4: The value of the dimension under search in every trial is floor((lo+hi)/2) of its current bracket. The first trial of each phase is therefore HEAD_MAX/2, CYL_MAX/2 and SEC_MAX/2.
- R5: When a trial is answered with pass=1, lo takes the trial value. When it is answered with pass=0, hi takes the trial value.
- R6: In every trial, each dimension already resolved carries its converged lo, and each dimension not yet searched carries 0.
- R7: A dimension has converged when lo = hi-1. After the sector dimension converges, `geom_valid_o` rises and each count output equals that dimension's lo+1. For a disk with H heads, C cylinders and S sectors, where a seek passes exactly when head<H, cyl<C and sec<S, the outputs are H, C and S.
- R8: At most one trial is outstanding. `trial_req_o` is a single-cycle pulse, and no new request appears before `trial_done_i` answers the previous one. The trial fields stay stable from the request until the answer. A `trial_done_i` in the same cycle as the request is accepted.
- R9: `trial_done_i` has no effect when no trial is outstanding. Before the first start, or after a result is valid, it raises no request and changes neither the valid flag nor the counts.
- R10: The three count outputs read 0 whenever `geom_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: clear all bounds and begin a new search |
| trial_req_o | output | 1 | One-cycle strobe: trial seek requested |
| trial_head_o | output | $clog2(HEAD_MAX+1) | Head index of the trial |
| trial_cyl_o | output | $clog2(CYL_MAX+1) | Cylinder index of the trial |
| trial_sec_o | output | $clog2(SEC_MAX+1) | Sector index of the trial |
| trial_done_i | input | 1 | Strobe: executor has finished the outstanding trial |
| trial_pass_i | input | 1 | Qualified by trial_done_i: 1 when the seek succeeded |
| geom_valid_o | output | 1 | Result counts are valid |
| heads_o | output | $clog2(HEAD_MAX+1) | Number of heads found |
| cyls_o | output | $clog2(CYL_MAX+1) | Number of cylinders found |
| secs_o | output | $clog2(SEC_MAX+1) | Number of sectors found |

## Verification
The hardest situation to reach from the ports is a restart that lands while a trial is still outstanding. In that case the pending answer must be forgotten, and the new search must not inherit any bracket state. The bench reaches it by aborting a run at a chosen trial index in each of the three phases, switching the modelled disk geometry at the same moment. It also varies the executor's response delay down to zero, so that the answer coincides with the request strobe. Every geometry at the extremes of each dimension is swept against an arithmetic disk model.

// File: rtl/geo_probe_pkg.sv
package geo_probe_pkg;

    typedef enum logic [1:0] {
        PR_IDLE = 2'd0,
        PR_PICK = 2'd1,
        PR_WAIT = 2'd2,
        PR_DONE = 2'd3
    } pr_state_e;

    typedef logic [1:0] dim_idx_t;

    localparam dim_idx_t DIM_HEAD = 2'd0;
    localparam dim_idx_t DIM_CYL  = 2'd1;
    localparam dim_idx_t DIM_SEC  = 2'd2;
    localparam int       NUM_DIMS = 3;

endpackage

// File: rtl/geo_bisect_dim.sv
// One dimension of the bisection: bracket registers, midpoint, settled value.
module geo_bisect_dim #(
    parameter int MAXV = 16,
    localparam int W = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         hit_i,
    input  logic         miss_i,
    input  logic         settle_i,
    output logic [W-1:0] mid_o,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] held_o,
    output logic         conv_o
);

    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic [W-1:0] held;
    } dim_t;

    localparam logic [W-1:0] TOP = W'(MAXV);

    dim_t d_q, d_d;
    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, d_q.lo} + {1'b0, d_q.hi};
        mid_o  = sum[W:1];
        conv_o = (W'(d_q.lo + 1'b1) == d_q.hi);
        lo_o   = d_q.lo;
        held_o = d_q.held;

        d_d = d_q;
        if (clr_i) begin
            d_d.lo   = '0;
            d_d.hi   = TOP;
            d_d.held = '0;
        end else begin
            if (hit_i)    d_d.lo   = mid_o;
            if (miss_i)   d_d.hi   = mid_o;
            if (settle_i) d_d.held = d_q.lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q.lo   <= '0;
            d_q.hi   <= TOP;
            d_q.held <= '0;
        end else begin
            d_q <= d_d;
        end
    end

endmodule

// File: rtl/geo_prober.sv
// Sequencer: issues trial seeks, walks dimensions, forms the result.
module geo_prober
    import geo_probe_pkg::*;
#(
    parameter int HEAD_MAX = 16,
    parameter int CYL_MAX  = 1024,
    parameter int SEC_MAX  = 64,
    localparam int HW = $clog2(HEAD_MAX + 1),
    localparam int CW = $clog2(CYL_MAX + 1),
    localparam int SW = $clog2(SEC_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          trial_req_o,
    output logic [HW-1:0] trial_head_o,
    output logic [CW-1:0] trial_cyl_o,
    output logic [SW-1:0] trial_sec_o,
    input  logic          trial_done_i,
    input  logic          trial_pass_i,
    output logic          geom_valid_o,
    output logic [HW-1:0] heads_o,
    output logic [CW-1:0] cyls_o,
    output logic [SW-1:0] secs_o
);

    typedef struct packed {
        pr_state_e     state;
        dim_idx_t      dim;
        logic          req;
        logic [HW-1:0] t_head;
        logic [CW-1:0] t_cyl;
        logic [SW-1:0] t_sec;
        logic          valid;
        logic [HW-1:0] n_head;
        logic [CW-1:0] n_cyl;
        logic [SW-1:0] n_sec;
    } seq_t;

    seq_t s_q, s_d;

    logic                clr;
    logic [NUM_DIMS-1:0] hit_v, miss_v, settle_v, conv_v;
    logic [HW-1:0]       h_mid, h_lo, h_held;
    logic [CW-1:0]       c_mid, c_lo, c_held;
    logic [SW-1:0]       s_mid, s_lo, s_held;

    geo_bisect_dim #(.MAXV(HEAD_MAX)) u_head (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .hit_i(hit_v[DIM_HEAD]), .miss_i(miss_v[DIM_HEAD]), .settle_i(settle_v[DIM_HEAD]),
        .mid_o(h_mid), .lo_o(h_lo), .held_o(h_held), .conv_o(conv_v[DIM_HEAD])
    );

    geo_bisect_dim #(.MAXV(CYL_MAX)) u_cyl (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .hit_i(hit_v[DIM_CYL]), .miss_i(miss_v[DIM_CYL]), .settle_i(settle_v[DIM_CYL]),
        .mid_o(c_mid), .lo_o(c_lo), .held_o(c_held), .conv_o(conv_v[DIM_CYL])
    );

    geo_bisect_dim #(.MAXV(SEC_MAX)) u_sec (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .hit_i(hit_v[DIM_SEC]), .miss_i(miss_v[DIM_SEC]), .settle_i(settle_v[DIM_SEC]),
        .mid_o(s_mid), .lo_o(s_lo), .held_o(s_held), .conv_o(conv_v[DIM_SEC])
    );

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        clr      = 1'b0;
        hit_v    = '0;
        miss_v   = '0;
        settle_v = '0;

        if (start_i) begin
            clr       = 1'b1;
            s_d.state = PR_PICK;
            s_d.dim   = DIM_HEAD;
            s_d.valid = 1'b0;
            s_d.n_head = '0;
            s_d.n_cyl  = '0;
            s_d.n_sec  = '0;
        end else begin
            unique case (s_q.state)
                PR_PICK: begin
                    if (conv_v[s_q.dim]) begin
                        settle_v[s_q.dim] = 1'b1;
                        if (s_q.dim == DIM_SEC) begin
                            s_d.state  = PR_DONE;
                            s_d.valid  = 1'b1;
                            s_d.n_head = HW'(h_lo + 1'b1);
                            s_d.n_cyl  = CW'(c_lo + 1'b1);
                            s_d.n_sec  = SW'(s_lo + 1'b1);
                        end else begin
                            s_d.dim = dim_idx_t'(s_q.dim + 1'b1);
                        end
                    end else begin
                        s_d.req    = 1'b1;
                        s_d.state  = PR_WAIT;
                        s_d.t_head = (s_q.dim == DIM_HEAD) ? h_mid : h_held;
                        s_d.t_cyl  = (s_q.dim == DIM_CYL)  ? c_mid : c_held;
                        s_d.t_sec  = (s_q.dim == DIM_SEC)  ? s_mid : s_held;
                    end
                end
                PR_WAIT: begin
                    if (trial_done_i) begin
                        hit_v[s_q.dim]  = trial_pass_i;
                        miss_v[s_q.dim] = ~trial_pass_i;
                        s_d.state       = PR_PICK;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: PR_IDLE, dim: DIM_HEAD, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign trial_req_o  = s_q.req;
    assign trial_head_o = s_q.t_head;
    assign trial_cyl_o  = s_q.t_cyl;
    assign trial_sec_o  = s_q.t_sec;
    assign geom_valid_o = s_q.valid;
    assign heads_o      = s_q.n_head;
    assign cyls_o       = s_q.n_cyl;
    assign secs_o       = s_q.n_sec;

endmodule

// File: rtl/geo_prober_chk.sv
module geo_prober_chk #(
    parameter int HEAD_MAX = 16,
    parameter int CYL_MAX  = 1024,
    parameter int SEC_MAX  = 64,
    localparam int HW = $clog2(HEAD_MAX + 1),
    localparam int CW = $clog2(CYL_MAX + 1),
    localparam int SW = $clog2(SEC_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          trial_req_o,
    input logic [HW-1:0] trial_head_o,
    input logic [CW-1:0] trial_cyl_o,
    input logic [SW-1:0] trial_sec_o,
    input logic          trial_done_i,
    input logic          geom_valid_o,
    input logic [HW-1:0] heads_o,
    input logic [CW-1:0] cyls_o,
    input logic [SW-1:0] secs_o
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pend_q <= 1'b0;
        else if (start_i)      pend_q <= 1'b0;
        else if (trial_req_o)  pend_q <= ~trial_done_i;
        else if (trial_done_i) pend_q <= 1'b0;
    end

    // R8: no second request while one is outstanding
    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trial_req_o |-> !pend_q);

    // R8: trial fields frozen while waiting for the answer
    p_fields_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !trial_done_i && !start_i) |=>
            ($stable(trial_head_o) && $stable(trial_cyl_o) && $stable(trial_sec_o)));

    // R2: restart drops valid and request
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!geom_valid_o && !trial_req_o));

    // R10: counts are zero without valid
    p_counts_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !geom_valid_o |-> (heads_o == '0 && cyls_o == '0 && secs_o == '0));

    // R7: reported counts lie within their ranges
    p_counts_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        geom_valid_o |-> (heads_o >= HW'(1) && heads_o <= HW'(HEAD_MAX) &&
                          cyls_o  >= CW'(1) && cyls_o  <= CW'(CYL_MAX)  &&
                          secs_o  >= SW'(1) && secs_o  <= SW'(SEC_MAX)));

    // R9: finished search issues no trials
    p_quiet_when_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        geom_valid_o |-> !trial_req_o);

endmodule

bind geo_prober geo_prober_chk #(
    .HEAD_MAX(HEAD_MAX), .CYL_MAX(CYL_MAX), .SEC_MAX(SEC_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .trial_req_o(trial_req_o), .trial_head_o(trial_head_o),
    .trial_cyl_o(trial_cyl_o), .trial_sec_o(trial_sec_o),
    .trial_done_i(trial_done_i), .geom_valid_o(geom_valid_o),
    .heads_o(heads_o), .cyls_o(cyls_o), .secs_o(secs_o)
);

// File: tb/geo_prober_test.sv
`timescale 1ns/1ps
module geo_prober_test;

    localparam int HMAX = 16;
    localparam int CMAX = 1024;
    localparam int SMAX = 64;
    localparam int HW = $clog2(HMAX + 1);
    localparam int CW = $clog2(CMAX + 1);
    localparam int SW = $clog2(SMAX + 1);
    localparam int HB = $clog2(HMAX);
    localparam int CB = $clog2(CMAX);
    localparam int SB = $clog2(SMAX);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          trial_req_o;
    logic [HW-1:0] trial_head_o;
    logic [CW-1:0] trial_cyl_o;
    logic [SW-1:0] trial_sec_o;
    logic          trial_done_i = 1'b0;
    logic          trial_pass_i = 1'b0;
    logic          geom_valid_o;
    logic [HW-1:0] heads_o;
    logic [CW-1:0] cyls_o;
    logic [SW-1:0] secs_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    geo_prober #(.HEAD_MAX(HMAX), .CYL_MAX(CMAX), .SEC_MAX(SMAX)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .trial_req_o(trial_req_o), .trial_head_o(trial_head_o),
        .trial_cyl_o(trial_cyl_o), .trial_sec_o(trial_sec_o),
        .trial_done_i(trial_done_i), .trial_pass_i(trial_pass_i),
        .geom_valid_o(geom_valid_o), .heads_o(heads_o),
        .cyls_o(cyls_o), .secs_o(secs_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!geom_valid_o, "R2", "valid after start", int'(geom_valid_o), 0);
        chk(!trial_req_o, "R2", "req after start", int'(trial_req_o), 0);
        chk(heads_o == 0 && cyls_o == 0 && secs_o == 0, "R10", "counts while invalid",
            int'(heads_o) + int'(cyls_o) + int'(secs_o), 0);
    endtask

    // One full search against disk (h,c,s); optional restart at trial abort_at
    // switching to disk (h2,c2,s2).
    task automatic run(input int h, input int c, input int s, input int lat,
                       input int abort_at, input int h2, input int c2, input int s2);
        int gh = h, gc = c, gs = s, ab = abort_at;
        int k = 0, lo = 0, hi = HMAX, cyc = 0, ph, mid;
        int eh, ec, es;
        bit fin = 0, p;
        logic [HW-1:0] rh;
        logic [CW-1:0] rc;
        logic [SW-1:0] rs;
        pulse_start();
        while (!fin) begin
            @(negedge clk);
            cyc++;
            if (cyc > 3000) begin
                chk(0, "R7", "search never finished", cyc, 0);
                fin = 1;
            end else if (geom_valid_o) begin
                chk(int'(heads_o) == gh, "R7", "heads result", int'(heads_o), gh);
                chk(int'(cyls_o) == gc, "R7", "cylinders result", int'(cyls_o), gc);
                chk(int'(secs_o) == gs, "R7", "sectors result", int'(secs_o), gs);
                chk(k == HB + CB + SB, "R3", "trial count", k, HB + CB + SB);
                fin = 1;
            end else if (trial_req_o) begin
                if (k == ab) begin
                    pulse_start();
                    gh = h2; gc = c2; gs = s2; k = 0; ab = -1; cyc = 0;
                end else begin
                    ph = (k < HB) ? 0 : (k < HB + CB) ? 1 : 2;
                    if (k == 0)       begin lo = 0; hi = HMAX; end
                    if (k == HB)      begin lo = 0; hi = CMAX; end
                    if (k == HB + CB) begin lo = 0; hi = SMAX; end
                    mid = (lo + hi) / 2;
                    eh = (ph == 0) ? mid : gh - 1;
                    ec = (ph == 1) ? mid : (ph > 1) ? gc - 1 : 0;
                    es = (ph == 2) ? mid : 0;
                    chk(int'(trial_head_o) == eh, (ph == 0) ? "R4" : "R6", "trial head",
                        int'(trial_head_o), eh);
                    chk(int'(trial_cyl_o) == ec, (ph == 1) ? "R4" : "R6", "trial cylinder",
                        int'(trial_cyl_o), ec);
                    chk(int'(trial_sec_o) == es, (ph == 2) ? "R4" : "R6", "trial sector",
                        int'(trial_sec_o), es);
                    p = (int'(trial_head_o) < gh) && (int'(trial_cyl_o) < gc) &&
                        (int'(trial_sec_o) < gs);
                    // R5: bracket update follows the answer
                    if (p) lo = mid; else hi = mid;
                    k++;
                    rh = trial_head_o; rc = trial_cyl_o; rs = trial_sec_o;
                    for (int w = 0; w < lat; w++) begin
                        @(negedge clk);
                        chk(!trial_req_o, "R8", "request while outstanding",
                            int'(trial_req_o), 0);
                        chk(rh == trial_head_o && rc == trial_cyl_o && rs == trial_sec_o,
                            "R8", "fields stable", int'(trial_cyl_o), int'(rc));
                    end
                    trial_done_i = 1'b1;
                    trial_pass_i = p;
                    @(negedge clk);
                    trial_done_i = 1'b0;
                    trial_pass_i = 1'b0;
                    chk(!trial_req_o, "R8", "request right after answer",
                        int'(trial_req_o), 0);
                end
            end
        end
    endtask

    task automatic spurious_done(input int eh, input int ec, input int es, input bit ev);
        trial_done_i = 1'b1;
        trial_pass_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!trial_req_o, "R9", "request from stray done", int'(trial_req_o), 0);
            chk(geom_valid_o == ev, "R9", "valid after stray done",
                int'(geom_valid_o), int'(ev));
            chk(int'(heads_o) == eh && int'(cyls_o) == ec && int'(secs_o) == es,
                "R9", "counts after stray done", int'(cyls_o), ec);
        end
        trial_done_i = 1'b0;
        trial_pass_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!geom_valid_o, "R1", "valid at reset", int'(geom_valid_o), 0);
        chk(!trial_req_o, "R1", "req at reset", int'(trial_req_o), 0);
        chk(heads_o == 0 && cyls_o == 0 && secs_o == 0, "R1", "counts at reset",
            int'(heads_o) + int'(cyls_o) + int'(secs_o), 0);
        repeat (4) @(negedge clk);
        chk(!trial_req_o, "R1", "no trial before start", int'(trial_req_o), 0);
        spurious_done(0, 0, 0, 1'b0);

        // heads sweep at both extremes of the other dimensions
        for (int h = 1; h <= HMAX; h++) begin
            run(h, CMAX, SMAX, idx % 3, -1, 0, 0, 0); idx++;
            run(h, 1, 1, idx % 3, -1, 0, 0, 0); idx++;
        end
        // sectors sweep
        for (int s = 1; s <= SMAX; s++) begin
            run(3, 700, s, idx % 3, -1, 0, 0, 0); idx++;
        end
        // cylinders sampled plus edges
        for (int c = 1; c <= CMAX; c += 37) begin
            run(7, c, 17, idx % 3, -1, 0, 0, 0); idx++;
        end
        run(5, 1023, 33, 0, -1, 0, 0, 0);
        run(5, 1024, 31, 1, -1, 0, 0, 0);
        run(5, 512, 32, 2, -1, 0, 0, 0);
        run(5, 513, 2, 0, -1, 0, 0, 0);
        spurious_done(5, 513, 2, 1'b1);

        // restarts mid-search in each phase, with different geometries
        run(16, 1024, 64, 1, 2, 1, 1, 1);
        run(2, 300, 9, 0, 7, 15, 999, 63);
        run(9, 77, 40, 2, 17, 4, 615, 17);
        run(1, 1, 1, 0, 0, 12, 1000, 50);
        spurious_done(12, 1000, 50, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule